// File: doc/BRIEF.md
# Step Attenuator Control Interface

This block produces the 6-bit control word for a digital step attenuator. The word can come from one of two sources, chosen by a mode input. The first source is six parallel control pins. The second is a serial bit stream carried on a data line and a strobe line. Each bit of the word has a binary weight. Bit 5 is worth 16 dB and bit 0 is worth 0.5 dB, so the word read as an unsigned number is the attenuation in half-decibel steps.

One latch-enable input gates both sources. While latch enable is high, the output follows the selected source. While it is low, the output holds. In parallel mode this gives two ways to work. With latch enable held high, the output tracks the pins directly. With latch enable low, new pin values are staged and then loaded by a high pulse. In serial mode the shift register keeps taking bits whatever the latch-enable level. The output changes only while latch enable is high.

All pins are asynchronous to the system clock, so each one passes through a two-stage synchronizer. When the block leaves reset, it waits until the synchronizers hold real samples. It then loads one defined start-up word. In serial mode that word is taken from the parallel pins. In parallel mode with latch enable low, it is picked by two start-up select pins. In parallel mode with latch enable high, it is taken from the parallel pins.

Top module: `step_atten_ctrl`

## Requirements
- R1: While `rst_n` is low, at every rising clock edge `atten_code_o` is cleared to 6'b000000.
- R2: After reset is released, the start-up word is loaded at the third rising edge. Its inputs are the values that were held from release onwards. With `mode_serial_i`=1 the start-up word is `par_word_i`, whatever `latch_en_i` and `start_sel_i` are.
- R3: With `mode_serial_i`=0 and `latch_en_i`=0 at start-up, `start_sel_i` picks the start-up word: 2'b00 gives 6'b000000, 2'b10 gives 6'b010000 (8 dB), 2'b01 gives 6'b100000 (16 dB), and 2'b11 gives 6'b111110 (31 dB).
- R4: With `mode_serial_i`=0 and `latch_en_i`=1 at start-up, `start_sel_i` is ignored and the start-up word is `par_word_i`.
- R5: In parallel mode with latch enable high, `atten_code_o` equals the value `par_word_i` held three clock edges earlier.
- R6: In parallel mode with latch enable low, `atten_code_o` holds while `par_word_i` changes. A high pulse on `latch_en_i` loads the new word, and the word stays after latch enable returns low.
- R7: Each rising edge of `ser_clk_i` shifts `ser_data_i` into a 6-bit register, most significant bit first: after six edges, the first bit sent is at bit 5. Shifting goes on while `latch_en_i` is low, and the output does not change meanwhile.
- R8: In serial mode with latch enable high, `atten_code_o` follows the shift register, one clock behind it. When latch enable falls, the last contents are held while further bits are shifted in.
- R9: `mode_serial_i`=0 selects the parallel source and 1 selects the serial source. The output word is the attenuation in 0.5 dB steps: all ones is 31.5 dB, and 6'b101111 is 23.5 dB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_serial_i | input | 1 | Source select: 0 parallel, 1 serial (asynchronous) |
| par_word_i | input | 6 | Parallel attenuation word, bit 5 = 16 dB (asynchronous) |
| ser_data_i | input | 1 | Serial data bit (asynchronous) |
| ser_clk_i | input | 1 | Serial shift strobe, rising edge active (asynchronous) |
| latch_en_i | input | 1 | Latch enable: high transparent, low hold (asynchronous) |
| start_sel_i | input | 2 | Start-up word select for parallel mode (asynchronous) |
| atten_code_o | output | 6 | Registered attenuation word |

## Verification
The assertions assume three things about the inputs. Each level of `ser_clk_i` lasts longer than the synchronizer depth, so no rising edge is lost. `ser_data_i` is stable around that edge. Every latch-enable pulse covers at least one synchronized cycle. The stimulus changes pins only at falling clock edges and keeps every serial strobe phase and every latch-enable pulse at least three clocks long. Start-up inputs are set before reset is released and held until the start-up word has loaded.

// File: rtl/step_atten_pkg.sv
// Package: shared width, word type and start-up decode for the step
// attenuator control interface. Assumes a 6-bit word with bit 5 = 16 dB.
package step_atten_pkg;
    localparam int CODE_W = 6;
    typedef logic [CODE_W-1:0] code_t;

    // Start-up word chosen by the two select bits in parallel mode.
    // sel[1] alone selects 8 dB, sel[0] alone 16 dB, both select 31 dB.
    function automatic code_t startup_word(input logic [1:0] sel);
        code_t w;
        case (sel)
            2'b10:   w = 6'b010000;
            2'b01:   w = 6'b100000;
            2'b11:   w = 6'b111110;
            default: w = '0;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/atten_sync.sv
// Module: multi-bit level synchronizer, STAGES flip-flops per bit.
// Assumes each bit is an independent level; no cross-bit coherence.
module atten_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift the raw sample through the flip-flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/atten_shifter.sv
// Module: serial input shift register. Detects the rising edge of the
// synchronized serial strobe and shifts data in MSB first.
// Assumes the strobe and data are already synchronized to clk.
module atten_shifter #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_s,
    input  logic             sdata_s,
    output logic             sclk_rise,
    output logic [WIDTH-1:0] shreg
);
    logic sclk_d;

    assign sclk_rise = sclk_s & ~sclk_d;

    // Remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    // Shift one bit in on each detected strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         shreg <= '0;
        else if (sclk_rise) shreg <= {shreg[WIDTH-2:0], sdata_s};
    end
endmodule

// File: rtl/atten_latch.sv
// Module: output latch and start-up sequencer. Waits SYNC_STAGES cycles
// after reset so the synchronizers hold real samples. It then loads the
// start-up word once. After that it acts as a latch that is transparent
// while latch enable is high.
// Assumes all inputs are synchronized to clk.
module atten_latch
    import step_atten_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_s,
    input  logic        le_s,
    input  code_t       par_s,
    input  logic [1:0]  sel_s,
    input  code_t       shreg,
    output logic        pu_done,
    output code_t       code
);
    localparam int CW = $clog2(SYNC_STAGES + 1);

    logic [CW-1:0] cnt;
    code_t         start_word;

    // Start-up source: the pins in serial mode or in direct parallel
    // mode, otherwise the select decode.
    always_comb begin
        if (mode_s || le_s) start_word = par_s;
        else                start_word = startup_word(sel_s);
    end

    // Run the start-up sequence, then the transparent latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            pu_done <= 1'b0;
            code    <= '0;
        end else if (!pu_done) begin
            if (cnt == CW'(SYNC_STAGES)) begin
                pu_done <= 1'b1;
                code    <= start_word;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (le_s) begin
            code <= mode_s ? shreg : par_s;
        end
    end
endmodule

// File: rtl/step_atten_ctrl.sv
// Module: step attenuator control interface (top). Synchronizes all pins,
// feeds the serial shifter and drives the latched attenuation word.
// Assumes the pins are asynchronous levels that are slow compared with clk.
module step_atten_ctrl
    import step_atten_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_serial_i,
    input  logic [5:0]  par_word_i,
    input  logic        ser_data_i,
    input  logic        ser_clk_i,
    input  logic        latch_en_i,
    input  logic [1:0]  start_sel_i,
    output logic [5:0]  atten_code_o
);
    localparam int BUS_W = CODE_W + 6;

    logic [BUS_W-1:0] raw_bus, sync_bus;
    logic             mode_s, le_s, sdata_s, sclk_s, sclk_rise, pu_done;
    logic [1:0]       sel_s;
    code_t            par_s, shreg, code;

    assign raw_bus = {mode_serial_i, latch_en_i, ser_data_i, ser_clk_i,
                      start_sel_i, par_word_i};
    assign {mode_s, le_s, sdata_s, sclk_s, sel_s, par_s} = sync_bus;

    atten_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
    );

    atten_shifter #(.WIDTH(CODE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .sdata_s(sdata_s),
        .sclk_rise(sclk_rise), .shreg(shreg)
    );

    atten_latch #(.SYNC_STAGES(SYNC_STAGES)) u_latch (
        .clk(clk), .rst_n(rst_n), .mode_s(mode_s), .le_s(le_s),
        .par_s(par_s), .sel_s(sel_s), .shreg(shreg),
        .pu_done(pu_done), .code(code)
    );

    assign atten_code_o = code;
endmodule

// File: rtl/step_atten_chk.sv
// Module: assertion checker for step_atten_ctrl, attached by bind.
// Assumes the synchronized signals seen here come from the top module.
module step_atten_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] atten_code_o,
    input logic       mode_s,
    input logic       le_s,
    input logic [5:0] par_s,
    input logic [5:0] shreg,
    input logic       sclk_rise,
    input logic       pu_done
);
    // R6: latch closed after start-up, so the output holds.
    a_r6_hold_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_done && !le_s) |=> $stable(atten_code_o));

    // R5: direct parallel mode, so the output takes the synchronized pins.
    a_r5_direct_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_done && le_s && !mode_s) |=> (atten_code_o == $past(par_s)));

    // R8: serial mode with latch open, so the output takes the shift register.
    a_r8_serial_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_done && le_s && mode_s) |=> (atten_code_o == $past(shreg)));

    // R7: each strobe edge moves the register up by one position.
    a_r7_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> (shreg[5:1] == $past(shreg[4:0])));

    // R7: without a strobe edge the shift register is unchanged.
    a_r7_no_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(shreg));

    // R2: once start-up is over it stays over until reset.
    a_r2_startup_once: assert property (@(posedge clk) disable iff (!rst_n)
        pu_done |=> pu_done);
endmodule

bind step_atten_ctrl step_atten_chk u_chk (
    .clk(clk), .rst_n(rst_n), .atten_code_o(atten_code_o),
    .mode_s(mode_s), .le_s(le_s), .par_s(par_s), .shreg(shreg),
    .sclk_rise(sclk_rise), .pu_done(pu_done)
);

// File: tb/step_atten_ctrl_test.sv
// Bench: a behavioural reference model built on a queue of pin snapshots,
// compared on every falling clock edge, plus directed checks per requirement.
module step_atten_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int DLY = 2;

    typedef struct packed {
        logic       mode;
        logic       le;
        logic       sd;
        logic       sc;
        logic [1:0] sel;
        logic [5:0] par;
    } snap_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_serial_i = 1'b0;
    logic [5:0] par_word_i = '0;
    logic       ser_data_i = 1'b0;
    logic       ser_clk_i = 1'b0;
    logic       latch_en_i = 1'b0;
    logic [1:0] start_sel_i = '0;
    logic [5:0] atten_code_o;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;
    string cur_req = "R1";

    step_atten_ctrl uut (
        .clk(clk), .rst_n(rst_n), .mode_serial_i(mode_serial_i),
        .par_word_i(par_word_i), .ser_data_i(ser_data_i),
        .ser_clk_i(ser_clk_i), .latch_en_i(latch_en_i),
        .start_sel_i(start_sel_i), .atten_code_o(atten_code_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state.
    snap_t      hist[$];
    logic [5:0] m_exp = '0;
    logic [5:0] m_sh = '0;
    int         m_wait = 0;
    bit         m_done = 0;

    function automatic logic [5:0] sel_to_word(input logic [1:0] sel);
        int half_db;
        half_db = 0;
        if (sel == 2'b10) half_db = 16;
        if (sel == 2'b01) half_db = 32;
        if (sel == 2'b11) half_db = 62;
        return half_db[5:0];
    endfunction

    always @(posedge clk) begin
        snap_t d2, d3, now;
        logic [5:0] old_sh;
        now = '{mode_serial_i, latch_en_i, ser_data_i, ser_clk_i,
                start_sel_i, par_word_i};
        if (!rst_n) begin
            hist.delete();
            m_exp = '0; m_sh = '0; m_wait = 0; m_done = 0;
        end else begin
            d2 = (hist.size() >= DLY)     ? hist[hist.size()-DLY]   : '0;
            d3 = (hist.size() >= DLY + 1) ? hist[hist.size()-DLY-1] : '0;
            old_sh = m_sh;
            if (!m_done) begin
                if (m_wait == DLY) begin
                    m_done = 1;
                    if (d2.mode || d2.le) m_exp = d2.par;
                    else                  m_exp = sel_to_word(d2.sel);
                end else begin
                    m_wait++;
                end
            end else if (d2.le) begin
                m_exp = d2.mode ? old_sh : d2.par;
            end
            if (d2.sc && !d3.sc) m_sh = {old_sh[4:0], d2.sd};
            hist.push_back(now);
            if (hist.size() > 6) void'(hist.pop_front());
        end
    end

    // Compare with the model on every falling edge.
    always @(negedge clk) begin
        if (!finished) begin
            checks++;
            if (atten_code_o !== m_exp) begin
                errors++;
                $display("FAIL %s model compare: actual %b expected %b",
                         cur_req, atten_code_o, m_exp);
            end
        end
    end

    task automatic check(input string req, input logic [5:0] exp);
        checks++;
        if (atten_code_o !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, atten_code_o, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic mode, input logic le,
                            input logic [1:0] sel, input logic [5:0] par);
        @(negedge clk);
        rst_n = 1'b0;
        mode_serial_i = mode; latch_en_i = le;
        start_sel_i = sel; par_word_i = par;
        ser_clk_i = 1'b0; ser_data_i = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(4);
    endtask

    task automatic send_word(input logic [5:0] w);
        for (int i = 5; i >= 0; i--) begin
            ser_data_i = w[i];
            wait_n(3);
            ser_clk_i = 1'b1;
            wait_n(3);
            ser_clk_i = 1'b0;
            wait_n(3);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: output cleared while reset is low.
        cur_req = "R1";
        par_word_i = 6'b111111;
        wait_n(4);
        check("R1", 6'b000000);

        // R3: parallel start-up words picked by the select pins.
        cur_req = "R3";
        do_reset(1'b0, 1'b0, 2'b00, 6'b110011); check("R3", 6'b000000);
        do_reset(1'b0, 1'b0, 2'b10, 6'b110011); check("R3", 6'b010000);
        do_reset(1'b0, 1'b0, 2'b01, 6'b110011); check("R3", 6'b100000);
        do_reset(1'b0, 1'b0, 2'b11, 6'b110011); check("R3", 6'b111110);

        // R4: latch enable high at start-up ignores the select pins.
        cur_req = "R4";
        do_reset(1'b0, 1'b1, 2'b11, 6'b001011); check("R4", 6'b001011);

        // R2: serial start-up takes the parallel pins.
        cur_req = "R2";
        do_reset(1'b1, 1'b0, 2'b11, 6'b101010); check("R2", 6'b101010);

        // R7: shift with latch closed; output unchanged, then loaded MSB first.
        cur_req = "R7";
        send_word(6'b110001);
        check("R7", 6'b101010);
        latch_en_i = 1'b1; wait_n(4);
        check("R7", 6'b110001);
        latch_en_i = 1'b0; wait_n(4);
        check("R7", 6'b110001);

        // R8: transparent serial latch follows, then holds when closed.
        cur_req = "R8";
        latch_en_i = 1'b1; wait_n(4);
        send_word(6'b000111);
        check("R8", 6'b000111);
        latch_en_i = 1'b0; wait_n(4);
        send_word(6'b011100);
        check("R8", 6'b000111);
        latch_en_i = 1'b1; wait_n(4);
        check("R8", 6'b011100);

        // R9: switching to parallel mode; full scale and a mid value.
        cur_req = "R9";
        mode_serial_i = 1'b0; par_word_i = 6'b111111; wait_n(4);
        check("R9", 6'b111111);
        par_word_i = 6'd47; wait_n(4);
        check("R9", 6'b101111);

        // R5: direct mode follows the pins.
        cur_req = "R5";
        par_word_i = 6'b000000; wait_n(4);
        check("R5", 6'b000000);
        par_word_i = 6'b100001; wait_n(4);
        check("R5", 6'b100001);

        // R6: latched parallel mode holds, then loads on a pulse.
        cur_req = "R6";
        latch_en_i = 1'b0; wait_n(4);
        par_word_i = 6'b010101; wait_n(4);
        check("R6", 6'b100001);
        par_word_i = 6'b011110; wait_n(4);
        check("R6", 6'b100001);
        latch_en_i = 1'b1; wait_n(3);
        latch_en_i = 1'b0; wait_n(4);
        check("R6", 6'b011110);
        par_word_i = 6'b000011; wait_n(4);
        check("R6", 6'b011110);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule